// File: doc/BRIEF.md
# SPI Chip-Select Timing Sequencer

This block is an SPI master transfer engine that wraps every frame in two programmable chip-select guard intervals and a trailing idle interval. When a transfer starts, the addressed chip-select line goes low. The block waits a programmed setup gap, shifts the frame out on SCK and MOSI while it samples MISO, and then keeps chip select low for a programmed hold gap. It then releases chip select and waits a programmed after-transfer gap. At the end it raises a one-cycle done pulse and presents the received word.

Eight timing configuration words are held inside the block and are written through a simple write port. Each start request names one of them, and the sequencer latches that word for the whole transfer. Each of the three gaps is an odd prescaler (1, 3, 5 or 7) times a power-of-two scaler 2^(s+1), so one gap can span from 2 to 7 x 65536 system clock cycles. The SCK half period and the frame length come from the same word.

Top module: `spi_cs_sequencer`

## Requirements
- R1: The setup gap is (2*p+1) * 2^(s+1) clocks, with p taken from config bits 23:22 and s from bits 15:12. It runs from the first cycle chip select is low to the first cycle SCK could go high. The first SCK high therefore appears gap + H cycles after chip select falls, where H is the SCK half period.
- R2: After the last SCK falling edge, chip select stays low for a hold gap of (2*p+1) * 2^(s+1) clocks, with p from bits 21:20 and s from bits 11:8.
- R3: After chip select is released, the block waits an after-transfer gap of (2*p+1) * 2^(s+1) clocks, with p from bits 19:18 and s from bits 7:4, before it raises done.
- R4: Prescaler and scaler codes of 0 give the shortest gap, which is 2 clocks. No gap is ever zero cycles long.
- R5: SCK idles low and pulses high only inside the shift phase. Each half period lasts H = b+1 clocks, with b taken from config bits 3:0.
- R6: A frame holds f+1 bits, with f taken from bits 30:27. Bits go out MSB first on MOSI from tx_data_i[f:0], and MOSI changes only while SCK is low. MISO is sampled at each SCK rising edge, and the result is right-aligned in rx_data_o.
- R7: The eight configuration words are written through cfg_we_i/cfg_waddr_i/cfg_wdata_i. The word named by cfg_sel_i is latched when a transfer starts.
- R8: Only the chip-select line named by cs_sel_i goes low, and only from the setup gap through the hold gap. All other lines stay high.
- R9: A start request that arrives while a transfer is in progress is ignored. The running transfer's timing, chip select and data are unchanged.
- R10: done_o is a single-cycle pulse. rx_data_o is valid with done_o and holds its value until the next transfer completes.
- R11: During and after reset, all chip-select lines are high, and SCK, MOSI and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration word write enable |
| cfg_waddr_i | input | CFG_AW | Index of the configuration word to write |
| cfg_wdata_i | input | 32 | Configuration word data |
| start_i | input | 1 | Start strobe, taken only when idle |
| cfg_sel_i | input | CFG_AW | Configuration word used by this transfer |
| cs_sel_i | input | CS_AW | Chip-select line used by this transfer |
| tx_data_i | input | 16 | Word to send, right-aligned |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the slave |
| cs_n_o | output | NUM_CS | Active-low chip-select lines |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| rx_data_o | output | 16 | Received word, right-aligned |

## Verification
The hardest state to reach from the ports is a start request that lands in the middle of a running transfer. Its index, chip select and data must all differ from those of the running transfer, so that a wrongly accepted request would show up. The bench raises such a strobe a chosen number of cycles into a transfer. It then checks that the measured gaps, the active line, the MOSI bit stream and the received word still match the first request. The long-gap corner is reached by one directed transfer whose setup scaler is 12. The shortest-gap corner is reached by an all-zero configuration word with a one-bit frame.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   localparam int CFG_W   = 32;
   localparam int FRAME_W = 16;
   localparam int FSZ_W   = 4;
   localparam int PRE_W   = 2;
   localparam int SC_W    = 4;
   localparam int HALF_W  = 4;
   localparam int GAP_W   = 3 + (1 << SC_W);

   localparam int FSZ_LSB        = 27;
   localparam int PRE_SETUP_LSB  = 22;
   localparam int PRE_HOLD_LSB   = 20;
   localparam int PRE_AFTER_LSB  = 18;
   localparam int SC_SETUP_LSB   = 12;
   localparam int SC_HOLD_LSB    = 8;
   localparam int SC_AFTER_LSB   = 4;
   localparam int HALF_LSB       = 0;

   typedef struct packed {
      logic [FSZ_W-1:0]  fsz;
      logic [PRE_W-1:0]  pre_setup;
      logic [PRE_W-1:0]  pre_hold;
      logic [PRE_W-1:0]  pre_after;
      logic [SC_W-1:0]   sc_setup;
      logic [SC_W-1:0]   sc_hold;
      logic [SC_W-1:0]   sc_after;
      logic [HALF_W-1:0] half;
   } xfer_cfg_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_SHIFT,
      ST_HOLD,
      ST_AFTER
   } seq_state_t;

endpackage

// File: rtl/spi_seq_cfg_bank.sv
module spi_seq_cfg_bank
   import spi_seq_pkg::*;
#(
   parameter int NUM_CFG = 8,
   localparam int AW = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             we_i,
   input  logic [AW-1:0]    waddr_i,
   input  logic [CFG_W-1:0] wdata_i,
   input  logic [AW-1:0]    raddr_i,
   output xfer_cfg_t        rdata_o
);

   xfer_cfg_t wr_fields;
   xfer_cfg_t entry [NUM_CFG];

   always_comb begin
      wr_fields.fsz       = wdata_i[FSZ_LSB       +: FSZ_W];
      wr_fields.pre_setup = wdata_i[PRE_SETUP_LSB +: PRE_W];
      wr_fields.pre_hold  = wdata_i[PRE_HOLD_LSB  +: PRE_W];
      wr_fields.pre_after = wdata_i[PRE_AFTER_LSB +: PRE_W];
      wr_fields.sc_setup  = wdata_i[SC_SETUP_LSB  +: SC_W];
      wr_fields.sc_hold   = wdata_i[SC_HOLD_LSB   +: SC_W];
      wr_fields.sc_after  = wdata_i[SC_AFTER_LSB  +: SC_W];
      wr_fields.half      = wdata_i[HALF_LSB      +: HALF_W];
   end

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{wdata_i[31], wdata_i[26:24], wdata_i[17:16]};

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_entry
      always_ff @(posedge clk_i) begin
         if (rst_i)
            entry[g] <= '0;
         else if (we_i && (waddr_i == AW'(g)))
            entry[g] <= wr_fields;
      end
   end

   assign rdata_o = entry[raddr_i];

   if (NUM_CFG < 2 || (NUM_CFG & (NUM_CFG - 1)) != 0) begin : g_bad_depth
      $error("spi_seq_cfg_bank: NUM_CFG must be a power of two >= 2");
   end

endmodule

// File: rtl/spi_seq_gap.sv
module spi_seq_gap
   import spi_seq_pkg::*;
#(
   parameter int LEN_W = GAP_W
) (
   input  logic [PRE_W-1:0] pre_i,
   input  logic [SC_W-1:0]  sc_i,
   output logic [LEN_W-1:0] len_o
);

   logic [PRE_W:0] odd_factor;

   assign odd_factor = {pre_i, 1'b1};
   assign len_o      = LEN_W'(odd_factor) << (LEN_W'(sc_i) + LEN_W'(1));

   if (LEN_W < PRE_W + 1 + (1 << SC_W)) begin : g_bad_width
      $error("spi_seq_gap: LEN_W too narrow for the largest gap");
   end

endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
   import spi_seq_pkg::*;
#(
   parameter int NUM_CS  = 4,
   parameter int NUM_CFG = 8,
   localparam int CS_AW  = $clog2(NUM_CS),
   localparam int CFG_AW = $clog2(NUM_CFG)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               cfg_we_i,
   input  logic [CFG_AW-1:0]  cfg_waddr_i,
   input  logic [CFG_W-1:0]   cfg_wdata_i,
   input  logic               start_i,
   input  logic [CFG_AW-1:0]  cfg_sel_i,
   input  logic [CS_AW-1:0]   cs_sel_i,
   input  logic [FRAME_W-1:0] tx_data_i,
   input  logic               miso_i,
   output logic               sck_o,
   output logic               mosi_o,
   output logic [NUM_CS-1:0]  cs_n_o,
   output logic               done_o,
   output logic [FRAME_W-1:0] rx_data_o
);

   if (NUM_CS < 2 || (NUM_CS & (NUM_CS - 1)) != 0) begin : g_bad_cs
      $error("spi_cs_sequencer: NUM_CS must be a power of two >= 2");
   end
   if (FRAME_W != (1 << FSZ_W)) begin : g_bad_frame
      $error("spi_cs_sequencer: frame width must match the size field");
   end

   xfer_cfg_t          cfg_rd;
   xfer_cfg_t          cfg_q;
   seq_state_t         state;
   logic [GAP_W-1:0]   cnt;
   logic [GAP_W-1:0]   cur_len;
   logic [GAP_W-1:0]   setup_len, hold_len, after_len, half_len;
   logic               cnt_last;
   logic               sck_q;
   logic               done_q;
   logic [CS_AW-1:0]   cs_q;
   logic [FRAME_W-1:0] tx_q, rx_q, rx_out;
   logic [FSZ_W-1:0]   bit_cnt;
   logic               cs_active;

   spi_seq_cfg_bank #(.NUM_CFG(NUM_CFG)) u_bank (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .we_i    (cfg_we_i),
      .waddr_i (cfg_waddr_i),
      .wdata_i (cfg_wdata_i),
      .raddr_i (cfg_sel_i),
      .rdata_o (cfg_rd)
   );

   spi_seq_gap u_gap_setup (.pre_i(cfg_q.pre_setup), .sc_i(cfg_q.sc_setup), .len_o(setup_len));
   spi_seq_gap u_gap_hold  (.pre_i(cfg_q.pre_hold),  .sc_i(cfg_q.sc_hold),  .len_o(hold_len));
   spi_seq_gap u_gap_after (.pre_i(cfg_q.pre_after), .sc_i(cfg_q.sc_after), .len_o(after_len));

   assign half_len = GAP_W'(cfg_q.half) + GAP_W'(1);

   always_comb begin
      case (state)
         ST_SETUP: cur_len = setup_len;
         ST_SHIFT: cur_len = half_len;
         ST_HOLD:  cur_len = hold_len;
         ST_AFTER: cur_len = after_len;
         default:  cur_len = GAP_W'(1);
      endcase
   end

   assign cnt_last = (cnt == cur_len - GAP_W'(1));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         sck_q   <= 1'b0;
         done_q  <= 1'b0;
         cfg_q   <= '0;
         cs_q    <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         rx_out  <= '0;
         bit_cnt <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  cfg_q   <= cfg_rd;
                  cs_q    <= cs_sel_i;
                  tx_q    <= tx_data_i << (~cfg_rd.fsz);
                  rx_q    <= '0;
                  bit_cnt <= cfg_rd.fsz;
                  cnt     <= '0;
                  state   <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (cnt_last) begin
                  cnt   <= '0;
                  state <= ST_SHIFT;
               end else begin
                  cnt <= cnt + GAP_W'(1);
               end
            end
            ST_SHIFT: begin
               if (cnt_last) begin
                  cnt <= '0;
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                     rx_q  <= {rx_q[FRAME_W-2:0], miso_i};
                  end else begin
                     sck_q <= 1'b0;
                     if (bit_cnt == '0) begin
                        state <= ST_HOLD;
                     end else begin
                        bit_cnt <= bit_cnt - FSZ_W'(1);
                        tx_q    <= tx_q << 1;
                     end
                  end
               end else begin
                  cnt <= cnt + GAP_W'(1);
               end
            end
            ST_HOLD: begin
               if (cnt_last) begin
                  cnt   <= '0;
                  state <= ST_AFTER;
               end else begin
                  cnt <= cnt + GAP_W'(1);
               end
            end
            ST_AFTER: begin
               if (cnt_last) begin
                  cnt    <= '0;
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                  rx_out <= rx_q;
               end else begin
                  cnt <= cnt + GAP_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cs_active = (state == ST_SETUP) || (state == ST_SHIFT) || (state == ST_HOLD);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign cs_n_o[g] = !(cs_active && (cs_q == CS_AW'(g)));
   end

   assign sck_o     = sck_q;
   assign mosi_o    = tx_q[FRAME_W-1];
   assign done_o    = done_q;
   assign rx_data_o = rx_out;

   // SCK only leaves its idle level inside the shift phase
   assert_sck_idle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (state != ST_SHIFT) |-> !sck_q);

   // at most one chip-select line is driven low
   assert_cs_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(~cs_n_o) <= 1);

   // done lasts exactly one cycle
   assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      done_q |=> !done_q);

   // a busy sequencer keeps its latched selection regardless of start
   assert_busy_latch_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (state != ST_IDLE) |=> ($stable(cs_q) && $stable(cfg_q)));

   // shortest setup and hold gaps are two cycles, never zero
   assert_setup_min_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (state == ST_SHIFT && $past(state) == ST_SETUP) |-> $past(state, 2) == ST_SETUP);
   assert_hold_min_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (state == ST_AFTER && $past(state) == ST_HOLD) |-> $past(state, 2) == ST_HOLD);

endmodule

// File: tb/sim_spi_cs_sequencer.sv
module sim_spi_cs_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int NCS  = 4;
   localparam int NCFG = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_waddr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        start = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [1:0]  cs_sel = '0;
   logic [15:0] tx_data = '0;
   logic        miso;
   logic        sck, mosi, done;
   logic [3:0]  cs_n;
   logic [15:0] rx_data;

   int checks = 0;
   int failures = 0;

   int b_fsz[NCFG], b_ps[NCFG], b_ph[NCFG], b_pa[NCFG];
   int b_ss[NCFG], b_sh[NCFG], b_sa[NCFG], b_br[NCFG];

   assign miso = ~mosi;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_cs_sequencer #(.NUM_CS(NCS), .NUM_CFG(NCFG)) u0 (
      .clk_i(clk), .rst_i(rst), .cfg_we_i(cfg_we), .cfg_waddr_i(cfg_waddr),
      .cfg_wdata_i(cfg_wdata), .start_i(start), .cfg_sel_i(cfg_sel),
      .cs_sel_i(cs_sel), .tx_data_i(tx_data), .miso_i(miso), .sck_o(sck),
      .mosi_o(mosi), .cs_n_o(cs_n), .done_o(done), .rx_data_o(rx_data)
   );

   function automatic int gap(input int p, input int s);
      return (2*p + 1) << (s + 1);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input int idx, input int fsz, input int ps, input int ph,
                            input int pa, input int ss, input int sh, input int sa, input int br);
      b_fsz[idx] = fsz; b_ps[idx] = ps; b_ph[idx] = ph; b_pa[idx] = pa;
      b_ss[idx] = ss;   b_sh[idx] = sh; b_sa[idx] = sa; b_br[idx] = br;
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_waddr = 3'(idx);
      cfg_wdata = (32'(fsz) << 27) | (32'(ps) << 22) | (32'(ph) << 20) | (32'(pa) << 18)
                | (32'(ss) << 12) | (32'(sh) << 8) | (32'(sa) << 4) | 32'(br);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_xfer(input int idx, input int csn, input logic [15:0] data, input int ign_at);
      int n = 0;
      int cs_low = 0, lead = 0, high = 0, tail = 0, after = 0, bits = 0;
      int bad_cs = 0, bad_sck = 0, mosi_moves = 0;
      bit seen_sck = 0, prev_sck = 0, prev_mosi = 0, got_done = 0;
      logic [15:0] mosi_acc = '0;
      int nb = b_fsz[idx] + 1;
      int h  = b_br[idx] + 1;
      logic [15:0] mask = 16'((32'd1 << nb) - 1);
      logic [15:0] held;

      @(negedge clk);
      start = 1'b1; cfg_sel = 3'(idx); cs_sel = 2'(csn); tx_data = data;
      @(negedge clk);
      start = 1'b0;
      while (!got_done && n < 200000) begin
         for (int k = 0; k < NCS; k++)
            if (k != csn && !cs_n[k]) bad_cs++;
         if (!cs_n[csn]) begin
            cs_low++;
            if (sck) begin
               if (!prev_sck) begin
                  bits++;
                  mosi_acc = {mosi_acc[14:0], mosi};
               end
               seen_sck = 1; high++; tail = 0;
            end else if (!seen_sck) begin
               lead++;
            end else begin
               tail++;
            end
            if (sck && n > 0 && mosi != prev_mosi) mosi_moves++;
         end else begin
            if (sck) bad_sck++;
            if (done) got_done = 1;
            else if (cs_low > 0) after++;
         end
         prev_sck = sck; prev_mosi = mosi;
         if (n == ign_at) begin
            start = 1'b1; cfg_sel = 3'((idx + 1) % NCFG);
            cs_sel = 2'((csn + 1) % NCS); tx_data = ~data;
         end else begin
            start = 1'b0;
         end
         if (!got_done) begin
            @(negedge clk);
            n++;
         end
      end
      check(got_done, "R10 done seen", int'(got_done), 1);
      check(lead == gap(b_ps[idx], b_ss[idx]) + h, "R1 setup lead", lead, gap(b_ps[idx], b_ss[idx]) + h);
      check(tail == gap(b_ph[idx], b_sh[idx]), "R2 hold tail", tail, gap(b_ph[idx], b_sh[idx]));
      check(after == gap(b_pa[idx], b_sa[idx]), "R3 after gap", after, gap(b_pa[idx], b_sa[idx]));
      check(high == h * nb, "R5 sck high time", high, h * nb);
      check(cs_low == gap(b_ps[idx], b_ss[idx]) + 2*h*nb + gap(b_ph[idx], b_sh[idx]),
            "R8 cs low span", cs_low, gap(b_ps[idx], b_ss[idx]) + 2*h*nb + gap(b_ph[idx], b_sh[idx]));
      check(bits == nb, "R6 bit count", bits, nb);
      check(mosi_acc == (data & mask), "R6 mosi stream", int'(mosi_acc), int'(data & mask));
      check(mosi_moves == 0, "R6 mosi stable with sck high", mosi_moves, 0);
      check(rx_data == (~data & mask), "R6 rx data", int'(rx_data), int'(~data & mask));
      check(bad_cs == 0, "R8 other cs lines high", bad_cs, 0);
      check(bad_sck == 0, "R5 sck idle outside cs", bad_sck, 0);
      held = rx_data;
      @(negedge clk);
      check(!done, "R10 done one cycle", int'(done), 0);
      check(rx_data == held, "R10 rx held", int'(rx_data), int'(held));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL R10 watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      check(cs_n == 4'hF, "R11 reset cs", int'(cs_n), 15);
      check(!sck && !mosi && !done, "R11 reset sck/mosi/done", int'({sck, mosi, done}), 0);
      rst = 1'b0;
      @(negedge clk);
      check(cs_n == 4'hF && !sck && !done, "R11 after reset idle", int'(cs_n), 15);

      // R4: all-zero codes, one-bit frame, shortest everything
      write_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
      run_xfer(0, 0, 16'h0001, -1);
      run_xfer(0, 3, 16'h0000, -1);

      // R7: distinct words at each index
      for (int i = 1; i < NCFG; i++)
         write_cfg(i, int'($urandom_range(15)), int'($urandom_range(3)), int'($urandom_range(3)),
                   int'($urandom_range(3)), int'($urandom_range(3)), int'($urandom_range(3)),
                   int'($urandom_range(3)), int'($urandom_range(3)));

      // R9: start pulses during busy phases (setup, shift, after)
      run_xfer(1, 1, 16'hA5C3, 1);
      run_xfer(2, 2, 16'h3C96, 20);
      run_xfer(3, 0, 16'hF00F, gap(b_ps[3], b_ss[3]) + 2*(b_br[3]+1)*(b_fsz[3]+1)
                                + gap(b_ph[3], b_sh[3]) + 1);

      for (int t = 0; t < 30; t++)
         run_xfer(int'($urandom_range(7)), int'($urandom_range(3)), 16'($urandom), -1);

      // R1: long setup gap, scaler 12, prescaler 7, full 16-bit frame
      write_cfg(7, 15, 3, 1, 2, 12, 2, 1, 1);
      run_xfer(7, 2, 16'h8001, -1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule